// File: doc/BRIEF.md
# Read Strobe and Data Delay Trainer

This block is a one-shot training controller for the read path of a double-data-rate memory interface. Once memory initialization has finished, it asks the memory controller to store a fixed 4-bit pattern at one address and then to read that address back continuously. Each read result holds four deserialized samples per data bit. The block steers the tap delay lines of the read strobe and of every data bit with single-cycle increment, decrement and reset pulses.

Training runs in two phases. In the first phase, the strobe and data delays move together, and data bit 0 is checked until it captures the pattern. If the strobe reaches the last tap without a match, a second pass starts with the strobe one tap ahead of the data. The strobe is then advanced on its own to measure how many taps the valid window spans. It is pulled back by half that count. In the second phase, the strobe stays fixed. Each data bit in turn is swept from tap 0 to find its first and last good taps, and is then parked on the floor of their midpoint.

Top module: `rd_strobe_trainer`

## Requirements
- R1: While `init_done` is low, the block requests nothing and pulses no delay line. When it starts, it pulses `dqs_rst` and every `dq_rst` bit in the same cycle.
- R2: `wr_req` stays high until `wr_ack` is sampled high. `rd_req` rises only after that acknowledge and stays high while calibration is in progress.
- R3: In the first phase, a comparison uses only data bit 0: `rd_q[3:0]` must equal `PATTERN`. Bit i always occupies `rd_q[4i+3:4i]`.
- R4: On a first-phase mismatch with the strobe below `MAX_TAP`, one cycle carries `dqs_inc` together with all `dq_inc` bits.
- R5: On a mismatch with the strobe at `MAX_TAP` in the first pass, all delays get a reset pulse. A single `dqs_inc` follows, and the joint sweep resumes from strobe tap 1 and data tap 0.
- R6: The first match sets the window count to 1. After that, only the strobe advances, and each matching step adds 1. Measurement ends at the first mismatch, or after a match at `MAX_TAP`.
- R7: After measurement, the strobe receives exactly (window count >> 1) `dqs_dec` pulses.
- R8: Data bits are handled in ascending order. Each bit gets a reset pulse and is then swept upward until a mismatch follows a match, or until `MAX_TAP`. Decrement pulses then leave it at floor((first match + last match) / 2).
- R9: After each increment or reset pulse, the block waits `SETTLE` cycles and then for a new `rd_valid` before it compares again. Two increment pulses are therefore at least `SETTLE+1` cycles apart.
- R10: `done` rises only after the last data bit has been centered.
- R11: `error` rises, and `done` stays low, in two cases: the second pass hits `MAX_TAP` without a match, or a data bit has no matching tap.
- R12: `done` and `error` hold until reset, or until `cal_start` is sampled high. Sampling `cal_start` clears them on the next cycle and restarts training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Memory initialization complete |
| cal_start | input | 1 | Clear the flags and retrain |
| wr_req | output | 1 | Request a pattern write |
| wr_ack | input | 1 | Write accepted |
| rd_req | output | 1 | Request back-to-back reads |
| rd_valid | input | 1 | New read result on `rd_q` |
| rd_q | input | 4*NBITS | Four samples per data bit |
| dqs_inc | output | 1 | Strobe tap increment pulse |
| dqs_dec | output | 1 | Strobe tap decrement pulse |
| dqs_rst | output | 1 | Strobe tap reset pulse |
| dq_inc | output | NBITS | Per-bit data tap increment pulses |
| dq_dec | output | NBITS | Per-bit data tap decrement pulses |
| dq_rst | output | NBITS | Per-bit data tap reset pulses |
| done | output | 1 | Calibration complete |
| error | output | 1 | Calibration failed |

## Verification
All adjustment pulses are registered. Each appears in the cycle after the edge that evaluated a read, or after the edge that handled the previous pulse. A new comparison cannot happen earlier than `SETTLE` cycles after the pulse, and then needs a new `rd_valid`. The bench follows every pulse at each rising edge to track tap positions, and it registers `rd_q` from those positions, so returned data lags a delay change by one cycle, as real capture logic would. `done` and `error` are sampled on falling edges. They change one cycle after the final decision, and they clear one cycle after `cal_start` is sampled; the bench checks them on the falling edge that follows that edge.

// File: rtl/rd_strobe_trainer.sv
module rd_strobe_trainer #(
  parameter int NBITS = 4,
  parameter int MAX_TAP = 63,
  parameter int SETTLE = 3,
  parameter logic [3:0] PATTERN = 4'b1011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_done,
  input  logic               cal_start,
  output logic               wr_req,
  input  logic               wr_ack,
  output logic               rd_req,
  input  logic               rd_valid,
  input  logic [4*NBITS-1:0] rd_q,
  output logic               dqs_inc,
  output logic               dqs_dec,
  output logic               dqs_rst,
  output logic [NBITS-1:0]   dq_inc,
  output logic [NBITS-1:0]   dq_dec,
  output logic [NBITS-1:0]   dq_rst,
  output logic               done,
  output logic               error
);
  localparam int TW = $clog2(MAX_TAP + 1);
  localparam int WW = TW + 1;
  localparam int CW = $clog2(SETTLE + 2);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_WR, S_WAIT, S_FB, S_DQS_DEC, S_BIT_RST, S_DQ_DEC, S_DONE, S_ERR
  } st_t;
  typedef enum logic [1:0] {P_SWEEP, P_WIN, P_BIT} ph_t;

  st_t st;
  ph_t ph;
  logic          fb, found;
  logic [TW-1:0] dqs_tap, dq_tap, first, last;
  logic [WW-1:0] win, dcnt;
  logic [BW-1:0] bi;
  logic [CW-1:0] cnt;

  logic [BW-1:0] bsel;
  logic [3:0]    smp;
  logic          hit, at_max, dq_max;
  logic [TW-1:0] firstv, lastv;
  logic [WW-1:0] sumv;
  logic [TW-1:0] midv;

  assign bsel   = (ph == P_BIT) ? bi : '0;
  assign smp    = rd_q[4*bsel +: 4];
  assign hit    = (smp == PATTERN);
  assign at_max = (dqs_tap == TW'(MAX_TAP));
  assign dq_max = (dq_tap == TW'(MAX_TAP));
  assign firstv = (hit && !found) ? dq_tap : first;
  assign lastv  = hit ? dq_tap : last;
  assign sumv   = {1'b0, firstv} + {1'b0, lastv};
  assign midv   = sumv[WW-1:1];

  assign wr_req = (st == S_WR);
  assign rd_req = (st == S_WAIT) || (st == S_FB) || (st == S_DQS_DEC) ||
                  (st == S_BIT_RST) || (st == S_DQ_DEC);
  assign done   = (st == S_DONE);
  assign error  = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_SWEEP;
      fb <= 1'b0;
      found <= 1'b0;
      dqs_tap <= '0;
      dq_tap <= '0;
      first <= '0;
      last <= '0;
      win <= '0;
      dcnt <= '0;
      bi <= '0;
      cnt <= '0;
      dqs_inc <= 1'b0;
      dqs_dec <= 1'b0;
      dqs_rst <= 1'b0;
      dq_inc <= '0;
      dq_dec <= '0;
      dq_rst <= '0;
    end else begin
      dqs_inc <= 1'b0;
      dqs_dec <= 1'b0;
      dqs_rst <= 1'b0;
      dq_inc <= '0;
      dq_dec <= '0;
      dq_rst <= '0;
      case (st)
        S_IDLE: if (init_done) begin
          dqs_rst <= 1'b1;
          dq_rst <= '1;
          dqs_tap <= '0;
          dq_tap <= '0;
          fb <= 1'b0;
          st <= S_WR;
        end
        S_WR: if (wr_ack) begin
          ph <= P_SWEEP;
          cnt <= CW'(SETTLE);
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (rd_valid) begin
            case (ph)
              P_SWEEP: begin
                if (hit) begin
                  win <= WW'(1);
                  if (at_max) begin
                    dcnt <= '0;
                    st <= S_DQS_DEC;
                  end else begin
                    dqs_inc <= 1'b1;
                    dqs_tap <= dqs_tap + 1'b1;
                    ph <= P_WIN;
                    cnt <= CW'(SETTLE);
                  end
                end else if (at_max) begin
                  if (fb) st <= S_ERR;
                  else begin
                    dqs_rst <= 1'b1;
                    dq_rst <= '1;
                    dqs_tap <= '0;
                    dq_tap <= '0;
                    fb <= 1'b1;
                    st <= S_FB;
                  end
                end else begin
                  dqs_inc <= 1'b1;
                  dq_inc <= '1;
                  dqs_tap <= dqs_tap + 1'b1;
                  dq_tap <= dq_tap + 1'b1;
                  cnt <= CW'(SETTLE);
                end
              end
              P_WIN: begin
                if (hit) begin
                  win <= win + 1'b1;
                  if (at_max) begin
                    dcnt <= (win + 1'b1) >> 1;
                    st <= S_DQS_DEC;
                  end else begin
                    dqs_inc <= 1'b1;
                    dqs_tap <= dqs_tap + 1'b1;
                    cnt <= CW'(SETTLE);
                  end
                end else begin
                  dcnt <= win >> 1;
                  st <= S_DQS_DEC;
                end
              end
              default: begin
                if (hit && !dq_max) begin
                  if (!found) first <= dq_tap;
                  found <= 1'b1;
                  last <= dq_tap;
                  dq_inc[bi] <= 1'b1;
                  dq_tap <= dq_tap + 1'b1;
                  cnt <= CW'(SETTLE);
                end else if (!hit && !found && !dq_max) begin
                  dq_inc[bi] <= 1'b1;
                  dq_tap <= dq_tap + 1'b1;
                  cnt <= CW'(SETTLE);
                end else if (!hit && !found) begin
                  st <= S_ERR;
                end else begin
                  dcnt <= {1'b0, dq_tap} - {1'b0, midv};
                  st <= S_DQ_DEC;
                end
              end
            endcase
          end
        end
        S_FB: begin
          dqs_inc <= 1'b1;
          dqs_tap <= TW'(1);
          cnt <= CW'(SETTLE);
          st <= S_WAIT;
        end
        S_DQS_DEC: begin
          if (dcnt == '0) begin
            bi <= '0;
            st <= S_BIT_RST;
          end else begin
            dqs_dec <= 1'b1;
            dqs_tap <= dqs_tap - 1'b1;
            dcnt <= dcnt - 1'b1;
          end
        end
        S_BIT_RST: begin
          dq_rst[bi] <= 1'b1;
          dq_tap <= '0;
          found <= 1'b0;
          ph <= P_BIT;
          cnt <= CW'(SETTLE);
          st <= S_WAIT;
        end
        S_DQ_DEC: begin
          if (dcnt == '0) begin
            if (bi == BW'(NBITS - 1)) st <= S_DONE;
            else begin
              bi <= bi + 1'b1;
              st <= S_BIT_RST;
            end
          end else begin
            dq_dec[bi] <= 1'b1;
            dcnt <= dcnt - 1'b1;
          end
        end
        S_DONE, S_ERR: if (cal_start) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_strobe_trainer_chk.sv
module rd_strobe_trainer_chk #(
  parameter int NBITS = 4,
  parameter int SETTLE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic             cal_start,
  input logic             wr_req,
  input logic             wr_ack,
  input logic             rd_req,
  input logic             dqs_inc,
  input logic [NBITS-1:0] dq_inc,
  input logic             done,
  input logic             error
);
  localparam logic [31:0] GMAX = 32'(SETTLE + 1);

  logic        wrote;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrote <= 1'b0;
      gap <= GMAX;
    end else begin
      if (wr_req && wr_ack) wrote <= 1'b1;
      else if (cal_start && (done || error)) wrote <= 1'b0;
      if (dqs_inc || (|dq_inc)) gap <= 32'd1;
      else if (gap != GMAX) gap <= gap + 32'd1;
    end
  end

  // R1
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> init_done);

  // R2
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> wrote);

  // R9
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_inc || (|dq_inc)) |-> (gap >= GMAX));

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_start) |=> done);

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !cal_start) |=> error);

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || error) && cal_start) |=> !(done || error));
endmodule

bind rd_strobe_trainer rd_strobe_trainer_chk #(.NBITS(NBITS), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .cal_start(cal_start),
  .wr_req(wr_req), .wr_ack(wr_ack), .rd_req(rd_req), .dqs_inc(dqs_inc),
  .dq_inc(dq_inc), .done(done), .error(error)
);

// File: tb/rd_strobe_trainer_bench.sv
module rd_strobe_trainer_bench;
  localparam int NB = 4;
  localparam int MT = 63;
  localparam int ST = 3;
  localparam logic [3:0] PAT = 4'b1011;
  localparam int NV = 5;
  // qlo, qhi, a, b, skew per bit, rd_valid period
  localparam int VEC [NV][6] = '{
    '{10, 40, -5,  6,  1, 1},
    '{ 5, 50,  1,  4,  0, 3},
    '{ 5, 50,  2,  4,  0, 1},
    '{60, 63, -3, 10,  0, 2},
    '{20, 40, -2,  2, 40, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, init_done = 1'b0, cal_start = 1'b0;
  logic wr_req, wr_ack = 1'b0, rd_req, rd_valid = 1'b0;
  logic [4*NB-1:0] rd_q = '0;
  logic dqs_inc, dqs_dec, dqs_rst, done, error;
  logic [NB-1:0] dq_inc, dq_dec, dq_rst;

  always #2 clk = ~clk;

  rd_strobe_trainer #(.NBITS(NB), .MAX_TAP(MT), .SETTLE(ST), .PATTERN(PAT)) u_rd_strobe_trainer (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cal_start(cal_start),
    .wr_req(wr_req), .wr_ack(wr_ack), .rd_req(rd_req), .rd_valid(rd_valid), .rd_q(rd_q),
    .dqs_inc(dqs_inc), .dqs_dec(dqs_dec), .dqs_rst(dqs_rst),
    .dq_inc(dq_inc), .dq_dec(dq_dec), .dq_rst(dq_rst), .done(done), .error(error));

  int checks = 0, errors = 0;
  int qlo, qhi, wa, wb, sk, per = 1;
  int m_dqs = 0;
  int m_dq [NB];
  int joint_cnt, rst_cnt, dec_cnt, min_gap, since_inc, next_bit, order_bad, pc = 0, ackcnt = 0;
  bit acked, rd_early;
  bit e_ok, e_a;
  int e_dqs, e_joint, e_rst, e_dec;
  int e_dq [NB];

  function automatic bit good(int s, int d, int i);
    return s >= qlo && s <= qhi && (s - d) >= wa + i*sk && (s - d) <= wb + i*sk;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rd_req && !acked) rd_early = 1'b1;
    if (wr_req && wr_ack) acked = 1'b1;
    if (dqs_inc && dq_inc == '1) joint_cnt++;
    if (dqs_rst) rst_cnt++;
    if (dqs_dec) dec_cnt++;
    if (dqs_inc || (|dq_inc)) begin
      if (since_inc < min_gap) min_gap = since_inc;
      since_inc = 1;
    end else since_inc++;
    if ($countones(dq_rst) == 1) begin
      if (!dq_rst[next_bit]) order_bad = 1;
      next_bit++;
    end
    if (dqs_rst) m_dqs = 0;
    else if (dqs_inc) m_dqs++;
    else if (dqs_dec) m_dqs--;
    for (int i = 0; i < NB; i++) begin
      if (dq_rst[i]) m_dq[i] = 0;
      else if (dq_inc[i]) m_dq[i]++;
      else if (dq_dec[i]) m_dq[i]--;
      rd_q[4*i +: 4] <= good(m_dqs, m_dq[i], i) ? PAT : ~PAT;
    end
    rd_valid <= (pc == 0);
    pc = (pc + 1) % per;
    if (wr_req && !wr_ack) begin
      ackcnt++;
      if (ackcnt == 4) wr_ack <= 1'b1;
    end else begin
      wr_ack <= 1'b0;
      ackcnt = 0;
    end
  end

  task automatic predict();
    int t = 0, off = 0, s, win, d, fi, la;
    bit f = 0, fnd;
    e_joint = 0; e_rst = 1; e_ok = 1; e_a = 0; e_dqs = 0; e_dec = 0;
    while (1) begin
      if (good(t + off, t, 0)) begin f = 1; break; end
      if (t + off == MT) begin
        if (off == 1) break;
        off = 1; t = 0; e_rst = 2;
      end else begin
        t++; e_joint++;
      end
    end
    if (!f) begin e_ok = 0; return; end
    e_a = 1;
    s = t + off; win = 1;
    while (s < MT) begin
      s++;
      if (good(s, t, 0)) win++;
      else break;
    end
    e_dec = win >> 1;
    s -= e_dec;
    e_dqs = s;
    for (int i = 0; i < NB; i++) begin
      fnd = 0; d = 0; fi = 0; la = 0;
      while (1) begin
        if (good(s, d, i)) begin
          if (!fnd) fi = d;
          fnd = 1; la = d;
          if (d == MT) break;
          d++;
        end else begin
          if (fnd) break;
          if (d == MT) begin e_ok = 0; return; end
          d++;
        end
      end
      e_dq[i] = (fi + la) / 2;
    end
  endtask

  task automatic clear_mon();
    joint_cnt = 0; rst_cnt = 0; dec_cnt = 0; min_gap = 1000000; since_inc = 1000000;
    next_bit = 0; order_bad = 0; acked = 0; rd_early = 0;
  endtask

  task automatic run_vec(int v, bit first);
    int n = 0;
    qlo = VEC[v][0]; qhi = VEC[v][1]; wa = VEC[v][2]; wb = VEC[v][3];
    sk = VEC[v][4]; per = VEC[v][5];
    predict();
    clear_mon();
    if (first) init_done = 1'b1;
    else begin
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      chk("R12 flags cleared after cal_start", int'(done || error), 0);
    end
    while (!(done || error) && n < 30000) begin
      @(negedge clk);
      n++;
    end
    chk("R12 watchdog", int'(n >= 30000), 0);
    chk("R10 done", int'(done), int'(e_ok));
    chk("R11 error", int'(error), int'(!e_ok));
    chk("R2 no read before write ack", int'(rd_early), 0);
    chk("R2 write acknowledged", int'(acked), 1);
    chk("R4 joint increments", joint_cnt, e_joint);
    chk("R5 strobe resets", rst_cnt, e_rst);
    chk("R9 increment spacing", int'(min_gap >= ST + 1), 1);
    if (e_a) begin
      chk("R7 strobe decrements", dec_cnt, e_dec);
      chk("R6 strobe tap", m_dqs, e_dqs);
    end
    if (e_ok) begin
      chk("R3 bit 0 tap", m_dq[0], e_dq[0]);
      for (int i = 1; i < NB; i++) chk("R8 bit tap", m_dq[i], e_dq[i]);
      chk("R8 bit order", order_bad, 0);
      chk("R8 bits visited", next_bit, NB);
    end
    repeat (10) @(negedge clk);
    chk("R12 flag held", int'(done || error), 1);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) m_dq[i] = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset error", int'(error), 0);
    chk("R1 reset rd_req", int'(rd_req), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no write before init", int'(wr_req), 0);
    chk("R1 no pulses before init", rst_cnt + joint_cnt + dec_cnt, 0);
    for (int v = 0; v < NV; v++) run_vec(v, v == 0);
    // directed: reset in mid-run
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset rd_req", int'(rd_req), 0);
    chk("R1 mid-run reset wr_req", int'(wr_req), 0);
    chk("R1 mid-run reset pulses", int'(dqs_inc || dqs_dec || (|dq_inc) || (|dq_dec)), 0);
    chk("R12 mid-run reset flags", int'(done || error), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule